// File: doc/BRIEF.md
# Boundary Shift Bus Codec

This block protects a 4-bit data stream that crosses a long on-chip bus. It guards against two hazards: single-wire upsets and worst-case coupling between neighbouring wires. The sending side forms a Hamming(7,4) codeword for each accepted word and places every codeword bit on two adjacent wires. The last wire of that 14-wire pattern can be dropped to save a track. Successive words alternate between two codebooks. One is the plain duplicated pattern. The other is the same pattern rotated by one wire around the 14-wire ring and then truncated in the same way. The plain form can only change polarity between neighbours at odd wire boundaries, and the rotated form only at even ones. Two consecutive bus words therefore never drive two neighbouring wires in opposite directions.

The receiving side keeps its own one-bit phase in step with the sender. It undoes the rotation and merges the two copies of each codeword bit. A single-error syndrome correction then recovers the data. When the two copies disagree, the first copy is taken and the syndrome repairs it if it was the wrong one, so a tie is never forced to a fixed value. The sender accepts a word whenever `in_valid` is high. `in_ready` is always high because the bus carries no back-pressure, so whatever consumes the receiver output must take each `out_valid` pulse as it comes. The bus pins of both ends are exposed separately so the wiring between them can be modelled outside.

Top module: `bsc_link`

## Requirements
- R1: While `rst_n` is low and on the first edge after its release, `bus_tx` is all zeros, `bus_tx_strb` is low and `out_valid` is low, and both ends start in the unshifted phase.
- R2: In the unshifted phase, wires 2i and 2i+1 both carry codeword bit i, i = 0..6. The data bits d0..d3 sit at codeword bits 2, 4, 5, 6. Bit 0 = d0^d1^d3, bit 1 = d0^d2^d3, bit 3 = d1^d2^d3. With puncturing, wire 13 is absent.
- R3: In the rotated phase, wire j carries what wire (j+1) mod 14 of the full 14-wire unshifted pattern carries, before the same truncation to the bus width.
- R4: Each accepted word updates `bus_tx` on the next edge with `bus_tx_strb` high for that one cycle, and flips the phase. Cycles without `in_valid` leave `bus_tx` and the phase unchanged and hold `bus_tx_strb` low.
- R5: Between any two consecutive `bus_tx` values, no two adjacent wires both toggle and end at different levels.
- R6: `out_valid` pulses exactly one cycle after `bus_rx_strb`, and on an undisturbed link `out_data` equals the word sent.
- R7: With any single wire of `bus_rx` inverted, in either phase, `out_data` still equals the word sent.
- R8: On an undisturbed link, `out_fixed` is low with every `out_valid` pulse.
- R9: `in_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Always high; the link never stalls |
| in_data | input | 4 | Data word to send |
| bus_tx | output | W (13 or 14) | Encoded wires driven onto the bus |
| bus_tx_strb | output | 1 | High for the cycle a new bus word is driven |
| bus_rx | input | W | Wires as seen at the far end |
| bus_rx_strb | input | 1 | Far-end copy of the strobe |
| out_valid | output | 1 | One-cycle pulse with a recovered word |
| out_data | output | 4 | Recovered data word |
| out_fixed | output | 1 | The merged codeword had a nonzero syndrome and was corrected |

## Verification
The bench builds the link with puncturing on, which gives 13 wires. This is the awkward case: in the rotated phase the first copy of codeword bit 0 falls on the dropped wire, so the decoder has to use a different copy there than in the plain phase. Every data value is sent with every single wire inverted, and the phases alternate on their own, so each wire's error path is covered in both codebooks. Random traffic with idle gaps and back-to-back bursts shows that the phase follows accepted words rather than clock cycles.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int DATA_W = 4;
  localparam int CW_W   = 7;
  localparam int FULL_W = 2 * CW_W;

  // Codeword bit k sits at Hamming position k+1.
  function automatic logic [CW_W-1:0] ham_enc(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] c;
    c[2] = d[0];
    c[4] = d[1];
    c[5] = d[2];
    c[6] = d[3];
    c[0] = d[0] ^ d[1] ^ d[3];
    c[1] = d[0] ^ d[2] ^ d[3];
    c[3] = d[1] ^ d[2] ^ d[3];
    return c;
  endfunction

  function automatic logic [2:0] ham_syn(input logic [CW_W-1:0] c);
    return {c[3] ^ c[4] ^ c[5] ^ c[6],
            c[1] ^ c[2] ^ c[5] ^ c[6],
            c[0] ^ c[2] ^ c[4] ^ c[6]};
  endfunction

  function automatic logic [DATA_W-1:0] ham_data(input logic [CW_W-1:0] c);
    return {c[6], c[5], c[4], c[2]};
  endfunction

  // Wire j takes wire j+1 around the full ring.
  function automatic logic [FULL_W-1:0] ring_fwd(input logic [FULL_W-1:0] x);
    return {x[0], x[FULL_W-1:1]};
  endfunction

  function automatic logic [FULL_W-1:0] ring_back(input logic [FULL_W-1:0] x);
    return {x[FULL_W-2:0], x[FULL_W-1]};
  endfunction
endpackage

// File: rtl/bsc_encoder.sv
module bsc_encoder
  import bsc_pkg::*;
#(
  parameter int W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] data,
  output logic [W-1:0]      bus,
  output logic              strb
);
  logic [CW_W-1:0]   cw;
  logic [FULL_W-1:0] dup;
  logic [W-1:0]      word;
  logic              phase;

  assign cw = ham_enc(data);

  for (genvar i = 0; i < CW_W; i++) begin : g_dup
    assign dup[2*i]   = cw[i];
    assign dup[2*i+1] = cw[i];
  end

  // Rotate on the full ring first, then drop the punctured tail.
  assign word = W'(phase ? ring_fwd(dup) : dup);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus   <= '0;
      strb  <= 1'b0;
      phase <= 1'b0;
    end else begin
      strb <= take;
      if (take) begin
        bus   <= word;
        phase <= ~phase;
      end
    end
  end
endmodule

// File: rtl/bsc_decoder.sv
module bsc_decoder
  import bsc_pkg::*;
#(
  parameter int W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      bus,
  input  logic              strb,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              fixed
);
  localparam bit PUNCT = (W < FULL_W);
  // Which copy of each codeword bit to trust first: bit set = even wire.
  localparam logic [CW_W-1:0] FIRST_PLAIN = '1;
  localparam logic [CW_W-1:0] FIRST_ROT   = PUNCT ? 7'h7E : 7'h7F;

  logic [FULL_W-1:0] full, dup;
  logic [CW_W-1:0]   merged, first, flip, repaired;
  logic [2:0]        syn;
  logic              phase;

  assign full  = FULL_W'(bus);
  assign dup   = phase ? ring_back(full) : full;
  assign first = phase ? FIRST_ROT : FIRST_PLAIN;

  for (genvar i = 0; i < CW_W; i++) begin : g_merge
    // On disagreement the first copy is taken; the syndrome repairs it.
    assign merged[i] = first[i] ? dup[2*i] : dup[2*i+1];
  end

  assign syn      = ham_syn(merged);
  assign flip     = (syn == 3'd0) ? '0 : (CW_W'(1) << (syn - 3'd1));
  assign repaired = merged ^ flip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      fixed <= 1'b0;
      phase <= 1'b0;
    end else begin
      valid <= strb;
      if (strb) begin
        data  <= ham_data(repaired);
        fixed <= (syn != 3'd0);
        phase <= ~phase;
      end
    end
  end
endmodule

// File: rtl/bsc_link.sv
module bsc_link
  import bsc_pkg::*;
#(
  parameter bit PUNCTURE = 1'b1,
  localparam int W = FULL_W - int'(PUNCTURE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [W-1:0]      bus_tx,
  output logic              bus_tx_strb,
  input  logic [W-1:0]      bus_rx,
  input  logic              bus_rx_strb,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fixed
);
  assign in_ready = 1'b1;

  bsc_encoder #(.W(W)) u_enc (
    .clk  (clk),
    .rst_n(rst_n),
    .take (in_valid),
    .data (in_data),
    .bus  (bus_tx),
    .strb (bus_tx_strb)
  );

  bsc_decoder #(.W(W)) u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .bus  (bus_rx),
    .strb (bus_rx_strb),
    .valid(out_valid),
    .data (out_data),
    .fixed(out_fixed)
  );
endmodule

// File: rtl/bsc_link_chk.sv
module bsc_link_chk #(
  parameter int W = 13
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] bus_tx,
  input logic         bus_tx_strb,
  input logic [W-1:0] bus_rx,
  input logic         bus_rx_strb,
  input logic         out_valid,
  input logic         out_fixed
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bus_tx == '0 && !bus_tx_strb && !out_valid));

  p_strobe_on_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> bus_tx_strb);

  p_idle_holds_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!bus_tx_strb && $stable(bus_tx)));

  p_no_opposite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tx_strb |-> ((((bus_tx ^ $past(bus_tx)) & ((bus_tx ^ $past(bus_tx)) >> 1))
                      & (bus_tx ^ (bus_tx >> 1))) == '0));

  p_out_follows_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rx_strb |=> out_valid);

  p_out_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rx_strb |=> !out_valid);

  p_clean_not_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rx_strb && bus_tx_strb && bus_rx == bus_tx) |=> !out_fixed);

  p_ready_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready);
endmodule

bind bsc_link bsc_link_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .bus_tx     (bus_tx),
  .bus_tx_strb(bus_tx_strb),
  .bus_rx     (bus_rx),
  .bus_rx_strb(bus_rx_strb),
  .out_valid  (out_valid),
  .out_fixed  (out_fixed)
);

// File: tb/bsc_link_bench.sv
module bsc_link_bench;
  localparam int  CLK_PERIOD = 10;
  localparam bit  PUNC = 1'b1;
  localparam int  W = 14 - int'(PUNC);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_data = '0;
  logic [W-1:0] bus_tx, bus_rx;
  logic         bus_tx_strb;
  logic [W-1:0] flip_mask = '0;
  logic         out_valid, out_fixed;
  logic [3:0]   out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit ph = 1'b0;
  logic [W-1:0] prev_bus = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_rx = bus_tx ^ flip_mask;

  bsc_link #(.PUNCTURE(PUNC)) u_bsc_link (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .bus_tx(bus_tx), .bus_tx_strb(bus_tx_strb),
    .bus_rx(bus_rx), .bus_rx_strb(bus_tx_strb), .out_valid(out_valid),
    .out_data(out_data), .out_fixed(out_fixed)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected wires computed from position-coverage parity, then duplicated.
  function automatic logic [W-1:0] expect_bus(input logic [3:0] d, input bit rot);
    logic [7:1] pos;
    logic [13:0] full;
    logic [W-1:0] w;
    int di = 0;
    pos = '0;
    for (int q = 1; q <= 7; q++)
      if ((q & (q - 1)) != 0) begin pos[q] = d[di]; di++; end
    for (int p = 1; p <= 4; p = p * 2)
      for (int q = 1; q <= 7; q++)
        if ((q & p) != 0 && q != p) pos[p] = pos[p] ^ pos[q];
    for (int j = 0; j < 14; j++) full[j] = pos[j/2 + 1];
    for (int j = 0; j < W; j++) w[j] = rot ? full[(j + 1) % 14] : full[j];
    return w;
  endfunction

  function automatic bit opposite(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int j = 0; j < W - 1; j++)
      if (a[j] != b[j] && a[j+1] != b[j+1] && b[j] != b[j+1]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_bus(input logic [3:0] d);
    logic [W-1:0] e;
    e = expect_bus(d, ph);
    check(bus_tx == e, ph ? "R3 rotated wires" : "R2 plain wires", 16'(bus_tx), 16'(e));
    check(bus_tx_strb == 1'b1, "R4 strobe after accept", 16'(bus_tx_strb), 16'd1);
    check(!opposite(prev_bus, bus_tx), "R5 opposite transition", 16'(prev_bus), 16'(bus_tx));
    check(in_ready == 1'b1, "R9 ready", 16'(in_ready), 16'd1);
    prev_bus = bus_tx;
    ph = ~ph;
  endtask

  task automatic send(input logic [3:0] d, input logic [W-1:0] flip);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; flip_mask = flip;
    @(negedge clk);
    in_valid = 1'b0;
    check_bus(d);
    @(negedge clk);
    check(out_valid == 1'b1, "R6 out_valid timing", 16'(out_valid), 16'd1);
    check(out_data == d, (flip == '0) ? "R6 clean data" : "R7 corrected data",
          16'(out_data), 16'(d));
    if (flip == '0)
      check(out_fixed == 1'b0, "R8 no fix on clean word", 16'(out_fixed), 16'd0);
    flip_mask = '0;
  endtask

  task automatic idle_check(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(bus_tx == prev_bus && !bus_tx_strb, "R4 idle holds bus",
            16'(bus_tx), 16'(prev_bus));
      check(!out_valid, "R6 no output when idle", 16'(out_valid), 16'd0);
    end
  endtask

  task automatic burst(input int n);
    logic [3:0] q [0:15];
    for (int k = 0; k < n; k++) q[k] = 4'($urandom);
    for (int k = 0; k <= n + 1; k++) begin
      @(negedge clk);
      if (k >= 1 && k <= n) check_bus(q[k-1]);
      if (k >= 2) begin
        check(out_valid, "R6 burst valid", 16'(out_valid), 16'd1);
        check(out_data == q[k-2], "R6 burst data", 16'(out_data), 16'(q[k-2]));
      end
      if (k < n) begin in_valid = 1'b1; in_data = q[k]; end
      else in_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(bus_tx == '0, "R1 reset bus", 16'(bus_tx), 16'd0);
    check(!bus_tx_strb && !out_valid, "R1 reset strobes",
          16'({bus_tx_strb, out_valid}), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_tx == '0 && !out_valid, "R1 after release", 16'(bus_tx), 16'd0);

    // Directed: the example word in both codebooks, and the extremes.
    send(4'b0111, '0);
    send(4'b0111, '0);
    send(4'h0, '0);
    send(4'hF, '0);
    idle_check(3);
    send(4'hA, '0);   // phase must continue from the word count, not the clock
    send(4'h5, '0);

    // Every data value with every single wire inverted (R7).
    for (int d = 0; d < 16; d++)
      for (int j = 0; j < W; j++)
        send(4'(d), W'(1) << j);

    burst(9);
    burst(4);

    // Random traffic with random single flips and idle gaps.
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] f;
      f = ($urandom % 2 == 0) ? '0 : (W'(1) << ($urandom % W));
      send(4'($urandom), f);
      if ($urandom % 8 == 0) idle_check(1 + $urandom % 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule